// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block holds the raw interrupt status of a serial controller. The status has three sources: transmit done, receive ready and receive overflow. Each source has a single-cycle set pulse. A status bit stays set after its pulse until a bus write to the clear selector writes a one to that bit.

The enable bits for the three sources are spread across a 32-bit control word. The block remaps them onto the status bit positions and ANDs them with the raw status to form the masked status. A registered interrupt line goes high whenever any masked bit is set.

The block also decodes a small write port. Only the clear selector acts on the status. Writes that target the raw or masked status views are dropped.

Top module: `intr_mask_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the raw status clears to 3'b000 and `irq` clears to 0.
- R2: A one on `evt_set` bit 0 (transmit done), bit 1 (receive ready) or bit 2 (receive overflow) sets the matching `raw_status` bit at the next clock edge. The bit then holds until it is cleared.
- R3: A write with `wr_en` high and `wr_sel` = 2'd0 (clear) clears each `raw_status` bit whose `wr_data` bit is one. Bits written with zero keep their value.
- R4: When a set pulse and a clear of the same bit fall in the same cycle, the bit is set afterwards.
- R5: `masked_status` bit 0 equals `raw_status` bit 0 AND `ctrl_word` bit 5, with no clock latency.
- R6: `masked_status` bit 1 equals `raw_status` bit 1 AND `ctrl_word` bit 4.
- R7: `masked_status` bit 2 equals `raw_status` bit 2 AND `ctrl_word` bit 6. No other `ctrl_word` bit has any effect on `masked_status` or `irq`.
- R8: `irq` is registered. After each clock edge it equals the OR of the `masked_status` bits as they stood just before that edge.
- R9: Writes with `wr_sel` = 2'd1 (raw view), 2'd2 (masked view) or 2'd3 (unused) leave `raw_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control word; enables at bits 5, 4 and 6 |
| evt_set | input | 3 | Set pulses: bit 0 transmit done, bit 1 receive ready, bit 2 overflow |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 2 | Write target: 0 clear, 1 raw view, 2 masked view, 3 unused |
| wr_data | input | 3 | Write data bits for the three sources |
| raw_status | output | 3 | Raw interrupt status |
| masked_status | output | 3 | Raw status ANDed with the remapped enables |
| irq | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach from the ports is a set pulse and a clear of the same bit in the same cycle while that bit is already set. It also has to be seen whether the registered interrupt then stays high or drops for a cycle. To get there, the stimulus first raises the bit, then drives the pulse and an all-ones clear together. A deterministic pseudo-random phase also mixes set, clear and dropped writes with changing control words. Throughout, a behavioural model checks the raw status, masked status and interrupt line on every cycle.

// File: rtl/intr_mask_pkg.sv
// Package: shared constants for the masked interrupt status unit.
// Assumes three interrupt sources and a 32-bit control word.
package intr_mask_pkg;

    localparam int NUM_SRC = 3;
    localparam int CTRL_W  = 32;

    // Status bit indices of the sources.
    localparam int SRC_TXDONE = 0;
    localparam int SRC_RXRDY  = 1;
    localparam int SRC_RXOVF  = 2;

    // Control-word bit that enables each status bit, indexed by status bit.
    localparam int EN_POS [NUM_SRC] = '{5, 4, 6};

    // Write target encoding.
    typedef enum logic [1:0] {
        SEL_CLEAR  = 2'd0,
        SEL_RAWV   = 2'd1,
        SEL_MASKV  = 2'd2,
        SEL_UNUSED = 2'd3
    } wr_target_e;

    // Mask of control-word bits that carry an enable.
    function automatic logic [CTRL_W-1:0] used_ctrl_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[EN_POS[i]] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/intr_en_remap.sv
// Module: gathers the scattered enable bits of the control word onto the
// status bit positions. Purely combinational.
// Assumes EN_POS entries are distinct and below CTRL_W.
module intr_en_remap
    import intr_mask_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int C_W   = CTRL_W
) (
    input  logic [C_W-1:0]   ctrl,
    output logic [N_SRC-1:0] en
);

    localparam logic [C_W-1:0] USED = used_ctrl_mask();

    // Pick one control bit per status position.
    for (genvar i = 0; i < N_SRC; i++) begin : g_pick
        assign en[i] = ctrl[EN_POS[i]];
    end

    // Bits without an enable are intentionally left without function.
    logic unused_ctrl;
    assign unused_ctrl = ^(ctrl & ~USED);

endmodule

// File: rtl/intr_raw_status.sv
// Module: one sticky status flop per source.
// Set pulses win over clears in the same cycle.
// Assumes set and clear vectors are already decoded and stable at the edge.
module intr_raw_status #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_vec,
    input  logic [N_SRC-1:0] clr_vec,
    output logic [N_SRC-1:0] status
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // Hold, set or clear one status bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (set_vec[i]) begin
                status[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                status[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/intr_irq_reg.sv
// Module: registers the OR of the masked status into the interrupt line.
// Assumes the masked vector is settled before each edge.
module intr_irq_reg #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] masked,
    output logic             irq_q
);

    // Capture whether any masked source is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |masked;
        end
    end

endmodule

// File: rtl/intr_mask_unit.sv
// Module: top of the masked interrupt status unit.
// It decodes the write port, keeps the raw status, masks it with the
// remapped enables and drives the registered interrupt line.
// Assumes a synchronous active-low reset and single-cycle write strobes.
module intr_mask_unit
    import intr_mask_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTRL_W-1:0]  ctrl_word,
    input  logic [NUM_SRC-1:0] evt_set,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] raw_status,
    output logic [NUM_SRC-1:0] masked_status,
    output logic               irq
);

    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] clr_vec;

    // Only the clear target acts on status; the read-only views drop writes.
    always_comb begin
        clr_vec = '0;
        if (wr_en && (wr_target_e'(wr_sel) == SEL_CLEAR)) begin
            clr_vec = wr_data;
        end
    end

    intr_en_remap #(.N_SRC(NUM_SRC), .C_W(CTRL_W)) u_remap (
        .ctrl (ctrl_word),
        .en   (en_vec)
    );

    intr_raw_status #(.N_SRC(NUM_SRC)) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt_set),
        .clr_vec (clr_vec),
        .status  (raw_status)
    );

    // Apply the enables to the raw status.
    assign masked_status = raw_status & en_vec;

    intr_irq_reg #(.N_SRC(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .masked (masked_status),
        .irq_q  (irq)
    );

endmodule

// File: rtl/intr_mask_chk.sv
// Module: assertion checker for the masked interrupt status unit,
// attached to every instance of the top by the bind below.
module intr_mask_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl_word,
    input logic [2:0]  evt_set,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [2:0]  wr_data,
    input logic [2:0]  raw_status,
    input logic [2:0]  masked_status,
    input logic        irq
);

    // R1: reset empties the status and drops the line.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (raw_status == 3'b000) && !irq);

    // R2: every pulsed source is set one cycle later.
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != 3'b000) |=> ((raw_status & $past(evt_set)) == $past(evt_set)));

    // R3: a clear write removes the bits it names that were not pulsed.
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> ((raw_status & $past(wr_data & ~evt_set)) == 3'b000));

    // R4: pulse and clear together leave the bit set.
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && (evt_set & wr_data) != 3'b000)
        |=> ((raw_status & $past(evt_set & wr_data)) == $past(evt_set & wr_data)));

    // R5: transmit-done enable lives at control bit 5.
    p_mask_txd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        masked_status[0] == (raw_status[0] & ctrl_word[5]));

    // R6: receive-ready enable lives at control bit 4.
    p_mask_rxr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        masked_status[1] == (raw_status[1] & ctrl_word[4]));

    // R7: overflow enable lives at control bit 6.
    p_mask_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        masked_status[2] == (raw_status[2] & ctrl_word[6]));

    // R8: the line follows the masked status one cycle late.
    p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq == $past(masked_status != 3'b000)));

    // R9: writes to the views or the unused target change nothing.
    p_ro_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'd0 && evt_set == 3'b000) |=> $stable(raw_status));

endmodule

bind intr_mask_unit intr_mask_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_word     (ctrl_word),
    .evt_set       (evt_set),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq           (irq)
);

// File: tb/sim_intr_mask_unit.sv
// Bench: drives the unit and compares it every cycle against a
// behavioural model kept in integers.
module sim_intr_mask_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [2:0]  evt_set = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [2:0]  wr_data = '0;
    logic [2:0]  raw_status;
    logic [2:0]  masked_status;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int m_raw = 0;
    int m_irq = 0;
    string cur_req = "R1";
    logic [31:0] lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;

    intr_mask_unit u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .evt_set(evt_set),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
    );

    // Enables as the requirements place them: status 0<-ctrl5, 1<-ctrl4, 2<-ctrl6.
    function automatic int model_en(input logic [31:0] c);
        int e;
        e = 0;
        if (c[5]) e += 1;
        if (c[4]) e += 2;
        if (c[6]) e += 4;
        return e;
    endfunction

    // Reference model step at each edge.
    always @(posedge clk) begin
        int clr;
        if (!rst_n) begin
            m_raw = 0;
            m_irq = 0;
        end else begin
            m_irq = ((m_raw & model_en(ctrl_word)) != 0) ? 1 : 0;
            clr = (wr_en && wr_sel == 2'd0) ? int'(wr_data) : 0;
            m_raw = int'(evt_set) | (m_raw & ~clr);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs, then drive the next inputs.
    task automatic step(input logic [2:0] s, input logic we, input logic [1:0] sel,
                        input logic [2:0] d, input logic [31:0] c);
        @(negedge clk);
        check({cur_req, " raw"}, int'(raw_status), m_raw);
        check("R5/R6/R7 masked", int'(masked_status), m_raw & model_en(ctrl_word));
        check("R8 irq", int'(irq), m_irq);
        evt_set = s; wr_en = we; wr_sel = sel; wr_data = d; ctrl_word = c;
    endtask

    task automatic idle(input logic [31:0] c);
        step(3'b000, 1'b0, 2'd0, 3'b000, c);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        check("R1 reset raw", int'(raw_status), 0);
        check("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;

        // R2: each source sets its own bit, all enabled.
        cur_req = "R2";
        for (int i = 0; i < 3; i++) begin
            step(3'b001 << i, 1'b0, 2'd0, 3'b000, 32'h70);
            idle(32'h70);
        end
        idle(32'h70);
        @(negedge clk);
        check("R2 all three held", int'(raw_status), 7);
        check("R8 irq high", int'(irq), 1);

        // R3: clear bits one at a time, zeros first.
        cur_req = "R3";
        step(3'b000, 1'b1, 2'd0, 3'b000, 32'h70);
        idle(32'h70);
        for (int i = 0; i < 3; i++) begin
            step(3'b000, 1'b1, 2'd0, 3'b001 << i, 32'h70);
            idle(32'h70);
        end
        idle(32'h70);
        @(negedge clk);
        check("R3 all cleared", int'(raw_status), 0);

        // R4: bit already set, pulse and clear together.
        cur_req = "R4";
        step(3'b010, 1'b0, 2'd0, 3'b000, 32'h70);
        step(3'b010, 1'b1, 2'd0, 3'b111, 32'h70);
        idle(32'h70);
        @(negedge clk);
        check("R4 set wins", int'(raw_status), 2);
        check("R4 irq stays", int'(irq), 1);
        step(3'b000, 1'b1, 2'd0, 3'b111, 32'h70);
        idle(32'h70);

        // R5/R6/R7: each enable alone, then unrelated bits only.
        cur_req = "R7";
        step(3'b111, 1'b0, 2'd0, 3'b000, 32'h20);
        idle(32'h20);
        @(negedge clk);
        check("R5 only bit0 masked", int'(masked_status), 1);
        idle(32'h10);
        idle(32'h10);
        @(negedge clk);
        check("R6 only bit1 masked", int'(masked_status), 2);
        idle(32'h40);
        idle(32'h40);
        @(negedge clk);
        check("R7 only bit2 masked", int'(masked_status), 4);
        idle(32'hFFFF_FF8F);
        idle(32'hFFFF_FF8F);
        @(negedge clk);
        check("R7 other bits no mask", int'(masked_status), 0);
        idle(32'hFFFF_FF8F);
        @(negedge clk);
        check("R7 other bits no irq", int'(irq), 0);

        // R9: writes to the views and the unused target are dropped.
        cur_req = "R9";
        step(3'b000, 1'b1, 2'd1, 3'b111, 32'h70);
        step(3'b000, 1'b1, 2'd2, 3'b111, 32'h70);
        step(3'b000, 1'b1, 2'd3, 3'b111, 32'h70);
        idle(32'h70);
        @(negedge clk);
        check("R9 status kept", int'(raw_status), 7);

        // Mixed pseudo-random traffic.
        cur_req = "R2/R3/R4";
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step((lfsr[3:0] == 4'd0) ? lfsr[6:4] : 3'b000, lfsr[7], lfsr[9:8],
                 lfsr[12:10], {lfsr[31:16], 9'd0, lfsr[15:13], 4'd0});
        end
        idle(32'h0);
        idle(32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule